// File: doc/BRIEF.md
# Dual-Clock Width-Converting FIFO

This block is a first-in first-out buffer with 4608 bits of storage. Its write side and its read side run on two unrelated clocks. Each side selects its own word width, either 9 or 18 bits. A 9-bit side sees 512 entries and an 18-bit side sees 256 entries. When the two widths differ, 9-bit words are packed into 18-bit words on the way through, or 18-bit words are split into 9-bit words.

Each side has its own flag, either full or empty, and its own threshold flag, either almost full or almost empty. Each side also has a fill-level vector, stated in its own word size, and a flush input that discards everything stored.

Inside the block, both pointers count in 9-bit units and carry one wrap bit. Each pointer crosses into the other clock domain as a single-bit-step code through a synchroniser chain. The read port shows the oldest entry whenever it is not empty, and a read pulse removes that entry.

Top module: `xclk_width_fifo`

## Requirements
- R1: After reset, the write side reports not full, level 0 and almost-full low. The read side reports empty, level 0 and almost-empty high.
- R2: WR_WIDTH and RD_WIDTH are each 9 or 18, chosen independently. The capacity is always 512 nine-bit units. Any other width stops elaboration.
- R3: Where the widths differ, the earlier 9-bit word sits in bits [8:0] of the 18-bit word and the later 9-bit word sits in bits [17:9]. An 18-bit word written to a 9-bit reader comes out as bits [8:0] first, then bits [17:9].
- R4: While rd_empty is low, rd_data shows the oldest stored word. A cycle with rd_en high removes that word.
- R5: wr_level gives the stored units as seen by the write side, divided by two for an 18-bit write port. It changes on the wr_clk edge that accepts a write.
- R6: rd_level gives the stored units as seen by the read side, divided by two for an 18-bit read port. Writes become visible on the read side after the synchroniser delay. An 18-bit reader stays empty while fewer than two units are stored.
- R7: wr_full is high when less than one write word of space is free. A write while full is ignored, and the stored data and the level stay unchanged.
- R8: A read while empty is ignored and leaves the read pointer unchanged.
- R9: wr_almost_full is high exactly when the stored units, as seen by the write side, are at least AFULL_UNITS.
- R10: rd_almost_empty is high exactly when the stored units, as seen by the read side, are at most AEMPTY_UNITS.
- R11: A wr_flush cycle moves the write pointer onto the synchronised read pointer and ignores wr_en in that cycle. Within a few cycles the read side shows empty with level 0, and later writes come out unchanged.
- R12: An rd_flush cycle moves the read pointer onto the synchronised write pointer and ignores rd_en in that cycle. rd_level is 0 on the next cycle, and within a few cycles wr_level is 0.
- R13: After a flush, either port may start at an odd unit offset. 18-bit accesses at an odd offset still keep the unit order.
- R14: Outside flush cycles, each step of a pointer changes at most one bit of the code that crosses to the other clock domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WR_WIDTH | Write word |
| wr_flush | input | 1 | Discard stored data (write side) |
| wr_full | output | 1 | No room for one write word |
| wr_almost_full | output | 1 | Stored units at least AFULL_UNITS |
| wr_level | output | 10 | Stored entries in write-port words |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side asynchronous reset, active low |
| rd_en | input | 1 | Remove the oldest word |
| rd_flush | input | 1 | Discard stored data (read side) |
| rd_data | output | RD_WIDTH | Oldest stored word |
| rd_empty | output | 1 | Fewer units than one read word |
| rd_almost_empty | output | 1 | Stored units at most AEMPTY_UNITS |
| rd_level | output | 10 | Stored entries in read-port words |

## Verification
The bench builds two copies of the block on the same pair of clocks. One writes 9-bit words and reads 18-bit words. The other writes 18-bit words and reads 9-bit words. Both use AFULL_UNITS=500, AEMPTY_UNITS=4 and a two-stage synchroniser, so packing and unpacking are exercised in both directions. Flushes taken at odd unit offsets reach the unaligned 18-bit accesses on each side. A full 512-unit fill through the narrow writer reaches the almost-full edge at 500 units, the full edge and a write issued while full.

// File: rtl/xwf_pkg.sv
`timescale 1ns/1ps
package xwf_pkg;
   localparam int UNIT_W      = 9;
   localparam int DEPTH_UNITS = 512;
   localparam int ROW_COUNT   = DEPTH_UNITS / 2;
   localparam int ADDR_W      = $clog2(DEPTH_UNITS);
   localparam int PTR_W       = ADDR_W + 1;
   localparam int ROW_W       = ADDR_W - 1;

   typedef logic [PTR_W-1:0]  ptr_t;
   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [ROW_W-1:0]  row_t;
   typedef logic [UNIT_W-1:0] unit_t;

   function automatic ptr_t bin_to_gray(ptr_t b);
      return b ^ (b >> 1);
   endfunction

   function automatic ptr_t gray_to_bin(ptr_t g);
      ptr_t b;
      b[PTR_W-1] = g[PTR_W-1];
      for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   // A side that steps by two units keeps bit 0 fixed, so only the upper
   // bits are Gray coded; a side stepping by one codes the whole pointer.
   function automatic ptr_t ptr_to_code(ptr_t b, logic pair_step);
      ptr_t h;
      if (!pair_step) return bin_to_gray(b);
      h = bin_to_gray(b >> 1);
      return {h[PTR_W-2:0], b[0]};
   endfunction

   function automatic ptr_t code_to_ptr(ptr_t c, logic pair_step);
      ptr_t h;
      if (!pair_step) return gray_to_bin(c);
      h = gray_to_bin(c >> 1);
      return {h[PTR_W-2:0], c[0]};
   endfunction
endpackage

// File: rtl/xwf_sync.sv
`timescale 1ns/1ps
module xwf_sync #(
   parameter int WIDTH  = 10,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("xwf_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/xwf_wr_ctl.sv
`timescale 1ns/1ps
module xwf_wr_ctl
   import xwf_pkg::*;
#(
   parameter int PORT_W   = 9,
   parameter int PEER_W   = 18,
   parameter int AF_UNITS = 500
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  logic  flush,
   input  ptr_t  peer_code,
   output addr_t addr,
   output ptr_t  code_q,
   output logic  push,
   output logic  full,
   output logic  almost_full,
   output ptr_t  level
);
   localparam int   STEP      = PORT_W / UNIT_W;
   localparam logic SELF_PAIR = (STEP == 2);
   localparam logic PEER_PAIR = (PEER_W == 2 * UNIT_W);
   localparam ptr_t STEP_P    = ptr_t'(STEP);
   localparam ptr_t FULL_AT   = ptr_t'(DEPTH_UNITS - STEP + 1);
   localparam ptr_t AF_P      = ptr_t'(AF_UNITS);
   localparam ptr_t CAP_P     = ptr_t'(DEPTH_UNITS);

   ptr_t ptr_q, ptr_d, peer_ptr, used;

   assign peer_ptr    = code_to_ptr(peer_code, PEER_PAIR);
   assign used        = ptr_q - peer_ptr;
   assign full        = used >= FULL_AT;
   assign push        = en && !full && !flush;
   assign almost_full = used >= AF_P;
   assign level       = SELF_PAIR ? (used >> 1) : used;
   assign addr        = ptr_q[ADDR_W-1:0];

   always_comb begin
      ptr_d = ptr_q;
      if (flush)     ptr_d = peer_ptr;
      else if (push) ptr_d = ptr_q + STEP_P;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr_q  <= '0;
         code_q <= '0;
      end else begin
         ptr_q  <= ptr_d;
         code_q <= ptr_to_code(ptr_d, SELF_PAIR);
      end

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CAP_P);
   assert_full_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && en && !flush) |=> $stable(ptr_q));
   assert_wr_code_step_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($countones(code_q ^ $past(code_q)) <= 1));
endmodule

// File: rtl/xwf_rd_ctl.sv
`timescale 1ns/1ps
module xwf_rd_ctl
   import xwf_pkg::*;
#(
   parameter int PORT_W   = 18,
   parameter int PEER_W   = 9,
   parameter int AE_UNITS = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  en,
   input  logic  flush,
   input  ptr_t  peer_code,
   output addr_t addr,
   output ptr_t  code_q,
   output logic  empty,
   output logic  almost_empty,
   output ptr_t  level
);
   localparam int   STEP      = PORT_W / UNIT_W;
   localparam logic SELF_PAIR = (STEP == 2);
   localparam logic PEER_PAIR = (PEER_W == 2 * UNIT_W);
   localparam ptr_t STEP_P    = ptr_t'(STEP);
   localparam ptr_t AE_P      = ptr_t'(AE_UNITS);
   localparam ptr_t CAP_P     = ptr_t'(DEPTH_UNITS);

   ptr_t ptr_q, ptr_d, peer_ptr, used;
   logic pop;

   assign peer_ptr     = code_to_ptr(peer_code, PEER_PAIR);
   assign used         = peer_ptr - ptr_q;
   assign empty        = used < STEP_P;
   assign pop          = en && !empty && !flush;
   assign almost_empty = used <= AE_P;
   assign level        = SELF_PAIR ? (used >> 1) : used;
   assign addr         = ptr_q[ADDR_W-1:0];

   always_comb begin
      ptr_d = ptr_q;
      if (flush)    ptr_d = peer_ptr;
      else if (pop) ptr_d = ptr_q + STEP_P;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         ptr_q  <= '0;
         code_q <= '0;
      end else begin
         ptr_q  <= ptr_d;
         code_q <= ptr_to_code(ptr_d, SELF_PAIR);
      end

   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && en && !flush) |=> $stable(ptr_q));
   assert_rd_used_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      used <= CAP_P);
   assert_rd_code_step_R14: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> ($countones(code_q ^ $past(code_q)) <= 1));
endmodule

// File: rtl/xwf_store.sv
`timescale 1ns/1ps
module xwf_store
   import xwf_pkg::*;
#(
   parameter int WR_W = 9,
   parameter int RD_W = 18
) (
   input  logic            wr_clk,
   input  logic            push,
   input  addr_t           wr_addr,
   input  logic [WR_W-1:0] wr_data,
   input  addr_t           rd_addr,
   output logic [RD_W-1:0] rd_data
);
   localparam int WR_STEP = WR_W / UNIT_W;
   localparam int RD_STEP = RD_W / UNIT_W;

   unit_t bank_q  [2];
   unit_t wr_unit [2];
   unit_t lo_unit, hi_unit;

   // Units of a write, earliest first.
   assign wr_unit[0] = wr_data[UNIT_W-1:0];
   if (WR_STEP == 2) begin : g_wr_pair
      assign wr_unit[1] = wr_data[2*UNIT_W-1:UNIT_W];
   end else begin : g_wr_single
      assign wr_unit[1] = '0;
   end

   // Even units live in bank 0, odd units in bank 1; an access of two units
   // starting at an odd unit touches bank 1 at its row and bank 0 one row on.
   for (genvar b = 0; b < 2; b++) begin : g_bank
      unit_t cells [ROW_COUNT];
      logic  wk, rk, we;
      row_t  wrow, rrow;

      assign wk   = 1'(b) ^ wr_addr[0];
      assign rk   = 1'(b) ^ rd_addr[0];
      assign wrow = wr_addr[ADDR_W-1:1] + row_t'(wr_addr[0] & wk);
      assign rrow = rd_addr[ADDR_W-1:1] + row_t'(rd_addr[0] & rk);
      assign we   = push && (!wk || (WR_STEP == 2));

      always_ff @(posedge wr_clk)
         if (we) cells[wrow] <= wr_unit[wk];

      assign bank_q[b] = cells[rrow];
   end

   assign lo_unit = bank_q[rd_addr[0]];
   assign hi_unit = bank_q[~rd_addr[0]];

   if (RD_STEP == 2) begin : g_rd_pair
      assign rd_data = {hi_unit, lo_unit};
   end else begin : g_rd_single
      assign rd_data = lo_unit;
      logic unused_hi;
      assign unused_hi = ^hi_unit;
   end
endmodule

// File: rtl/xclk_width_fifo.sv
`timescale 1ns/1ps
module xclk_width_fifo
   import xwf_pkg::*;
#(
   parameter int WR_WIDTH     = 9,
   parameter int RD_WIDTH     = 18,
   parameter int AFULL_UNITS  = 500,
   parameter int AEMPTY_UNITS = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic                wr_clk,
   input  logic                wr_rst_n,
   input  logic                wr_en,
   input  logic [WR_WIDTH-1:0] wr_data,
   input  logic                wr_flush,
   output logic                wr_full,
   output logic                wr_almost_full,
   output logic [PTR_W-1:0]    wr_level,
   input  logic                rd_clk,
   input  logic                rd_rst_n,
   input  logic                rd_en,
   input  logic                rd_flush,
   output logic [RD_WIDTH-1:0] rd_data,
   output logic                rd_empty,
   output logic                rd_almost_empty,
   output logic [PTR_W-1:0]    rd_level
);
   // R2: only the two supported widths elaborate.
   if (WR_WIDTH != UNIT_W && WR_WIDTH != 2 * UNIT_W) begin : g_bad_wr_width
      $error("xclk_width_fifo: WR_WIDTH must be 9 or 18");
   end
   if (RD_WIDTH != UNIT_W && RD_WIDTH != 2 * UNIT_W) begin : g_bad_rd_width
      $error("xclk_width_fifo: RD_WIDTH must be 9 or 18");
   end
   if (AFULL_UNITS < 1 || AFULL_UNITS > DEPTH_UNITS) begin : g_bad_afull
      $error("xclk_width_fifo: AFULL_UNITS out of range");
   end
   if (AEMPTY_UNITS < 0 || AEMPTY_UNITS >= DEPTH_UNITS) begin : g_bad_aempty
      $error("xclk_width_fifo: AEMPTY_UNITS out of range");
   end

   addr_t wr_addr, rd_addr;
   ptr_t  wr_code, rd_code, wr_code_at_rd, rd_code_at_wr;
   ptr_t  wr_level_i, rd_level_i;
   logic  push;

   xwf_wr_ctl #(.PORT_W(WR_WIDTH), .PEER_W(RD_WIDTH), .AF_UNITS(AFULL_UNITS)) u_wr (
      .clk(wr_clk), .rst_n(wr_rst_n), .en(wr_en), .flush(wr_flush),
      .peer_code(rd_code_at_wr), .addr(wr_addr), .code_q(wr_code), .push(push),
      .full(wr_full), .almost_full(wr_almost_full), .level(wr_level_i));

   xwf_rd_ctl #(.PORT_W(RD_WIDTH), .PEER_W(WR_WIDTH), .AE_UNITS(AEMPTY_UNITS)) u_rd (
      .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .flush(rd_flush),
      .peer_code(wr_code_at_rd), .addr(rd_addr), .code_q(rd_code),
      .empty(rd_empty), .almost_empty(rd_almost_empty), .level(rd_level_i));

   xwf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
      .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_code), .q(wr_code_at_rd));

   xwf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
      .clk(wr_clk), .rst_n(wr_rst_n), .d(rd_code), .q(rd_code_at_wr));

   xwf_store #(.WR_W(WR_WIDTH), .RD_W(RD_WIDTH)) u_store (
      .wr_clk(wr_clk), .push(push), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data));

   assign wr_level = wr_level_i;
   assign rd_level = rd_level_i;
endmodule

// File: tb/xclk_width_fifo_bench.sv
`timescale 1ns/1ps
module xclk_width_fifo_bench;
   logic wr_clk = 0, rd_clk = 0, rst_n = 0;
   always #2 wr_clk = ~wr_clk;   // 250 MHz
   always #3 rd_clk = ~rd_clk;

   int n_checks = 0, n_err = 0;

   // DUT A: 9-bit writes, 18-bit reads
   logic a_wen = 0, a_wflush = 0, a_ren = 0, a_rflush = 0;
   logic [8:0] a_wdata = '0;
   logic [17:0] a_rdata;
   logic a_full, a_af, a_empty, a_ae;
   logic [9:0] a_wlvl, a_rlvl;

   // DUT B: 18-bit writes, 9-bit reads
   logic b_wen = 0, b_wflush = 0, b_ren = 0, b_rflush = 0;
   logic [17:0] b_wdata = '0;
   logic [8:0] b_rdata;
   logic b_full, b_af, b_empty, b_ae;
   logic [9:0] b_wlvl, b_rlvl;

   xclk_width_fifo #(.WR_WIDTH(9), .RD_WIDTH(18), .AFULL_UNITS(500), .AEMPTY_UNITS(4)) u_xclk_width_fifo (
      .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(a_wen), .wr_data(a_wdata), .wr_flush(a_wflush),
      .wr_full(a_full), .wr_almost_full(a_af), .wr_level(a_wlvl),
      .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(a_ren), .rd_flush(a_rflush),
      .rd_data(a_rdata), .rd_empty(a_empty), .rd_almost_empty(a_ae), .rd_level(a_rlvl));

   xclk_width_fifo #(.WR_WIDTH(18), .RD_WIDTH(9), .AFULL_UNITS(500), .AEMPTY_UNITS(4)) u_xclk_width_fifo_b (
      .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_en(b_wen), .wr_data(b_wdata), .wr_flush(b_wflush),
      .wr_full(b_full), .wr_almost_full(b_af), .wr_level(b_wlvl),
      .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_en(b_ren), .rd_flush(b_rflush),
      .rd_data(b_rdata), .rd_empty(b_empty), .rd_almost_empty(b_ae), .rd_level(b_rlvl));

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic a_push(input logic [8:0] v);
      @(negedge wr_clk); a_wen = 1; a_wdata = v;
      @(negedge wr_clk); a_wen = 0;
   endtask
   task automatic b_push(input logic [17:0] v);
      @(negedge wr_clk); b_wen = 1; b_wdata = v;
      @(negedge wr_clk); b_wen = 0;
   endtask
   task automatic a_pop(output logic [17:0] v);
      @(negedge rd_clk); v = a_rdata; a_ren = 1;
      @(negedge rd_clk); a_ren = 0;
   endtask
   task automatic b_pop(output logic [8:0] v);
      @(negedge rd_clk); v = b_rdata; b_ren = 1;
      @(negedge rd_clk); b_ren = 0;
   endtask
   task automatic settle();
      repeat (10) @(negedge rd_clk);
      repeat (4) @(negedge wr_clk);
   endtask

   function automatic logic [8:0] fill_val(int i);
      return 9'((i * 37 + 5) % 512);
   endfunction

   task automatic t_reset();
      check("R1", "A wr_full", a_full, 0);
      check("R1", "A wr_level", a_wlvl, 0);
      check("R1", "A wr_almost_full", a_af, 0);
      check("R1", "A rd_empty", a_empty, 1);
      check("R1", "A rd_level", a_rlvl, 0);
      check("R1", "A rd_almost_empty", a_ae, 1);
      check("R1", "B rd_empty", b_empty, 1);
   endtask

   task automatic t_pack();
      logic [17:0] w;
      for (int i = 0; i < 6; i++) a_push(9'h101 + 9'(i));
      check("R5", "A wr_level after 6 units", a_wlvl, 6);
      settle();
      check("R6", "A rd_level 6 units as pairs", a_rlvl, 3);
      check("R4", "A rd_empty with data", a_empty, 0);
      for (int j = 0; j < 3; j++) begin
         a_pop(w);
         check("R3", "A packed word", w, {9'h102 + 9'(2*j), 9'h101 + 9'(2*j)});
      end
      check("R4", "A empty after drain", a_empty, 1);
      settle();
      check("R5", "A wr_level after drain", a_wlvl, 0);
   endtask

   task automatic t_odd_unit();
      logic [17:0] w;
      a_push(9'h0AA);
      settle();
      check("R6", "A wide reader empty on one unit", a_empty, 1);
      check("R6", "A rd_level on one unit", a_rlvl, 0);
      a_push(9'h055);
      settle();
      a_pop(w);
      check("R3", "A pair completed", w, {9'h055, 9'h0AA});
   endtask

   task automatic t_unpack();
      logic [8:0] u;
      b_push({9'h1B2, 9'h1B1});
      b_push({9'h1B4, 9'h1B3});
      check("R5", "B wr_level wide words", b_wlvl, 2);
      settle();
      check("R6", "B rd_level units", b_rlvl, 4);
      check("R10", "B almost_empty at threshold", b_ae, 1);
      for (int j = 0; j < 4; j++) begin
         b_pop(u);
         check("R3", "B unpack order", u, 9'h1B1 + 9'(j));
      end
   endtask

   task automatic t_almost_empty();
      logic [8:0] u;
      for (int j = 0; j < 3; j++) b_push({9'h0C0 + 9'(2*j+1), 9'h0C0 + 9'(2*j)});
      settle();
      check("R6", "B rd_level 6", b_rlvl, 6);
      check("R10", "B almost_empty above threshold", b_ae, 0);
      b_pop(u);
      check("R10", "B almost_empty at 5", b_ae, 0);
      check("R6", "B rd_level after pop", b_rlvl, 5);
      b_pop(u);
      check("R10", "B almost_empty at 4", b_ae, 1);
      check("R4", "B second unit", u, 9'h0C1);
      for (int j = 2; j < 6; j++) begin
         b_pop(u);
         check("R4", "B order", u, 9'h0C0 + 9'(j));
      end
   endtask

   task automatic t_wr_flush_unaligned();
      logic [8:0] u;
      b_push({9'h0E2, 9'h0E1});
      settle();
      b_pop(u);
      check("R4", "B first half", u, 9'h0E1);
      settle();
      check("R11", "B rd_level before flush", b_rlvl, 1);
      @(negedge wr_clk); b_wflush = 1; b_wen = 1; b_wdata = 18'h3FFFF;
      @(negedge wr_clk); b_wflush = 0; b_wen = 0;
      check("R11", "B wr_level after flush", b_wlvl, 0);
      settle();
      check("R11", "B rd_empty after flush", b_empty, 1);
      check("R11", "B rd_level after flush", b_rlvl, 0);
      b_push({9'h0D2, 9'h0D1});
      settle();
      check("R13", "B rd_level odd-offset write", b_rlvl, 2);
      b_pop(u);
      check("R13", "B odd-offset low unit", u, 9'h0D1);
      b_pop(u);
      check("R13", "B odd-offset high unit", u, 9'h0D2);
   endtask

   task automatic t_rd_flush_unaligned();
      logic [17:0] w;
      for (int i = 0; i < 3; i++) a_push(9'h0E1 + 9'(i));
      check("R5", "A wr_level 3", a_wlvl, 3);
      settle();
      check("R6", "A rd_level 3 units", a_rlvl, 1);
      @(negedge rd_clk); a_rflush = 1; a_ren = 1;
      @(negedge rd_clk); a_rflush = 0; a_ren = 0;
      check("R12", "A rd_level after flush", a_rlvl, 0);
      check("R12", "A rd_empty after flush", a_empty, 1);
      settle();
      check("R12", "A wr_level after flush", a_wlvl, 0);
      for (int i = 0; i < 4; i++) a_push(9'h0F1 + 9'(i));
      settle();
      a_pop(w);
      check("R13", "A odd-offset pair 0", w, {9'h0F2, 9'h0F1});
      a_pop(w);
      check("R13", "A odd-offset pair 1", w, {9'h0F4, 9'h0F3});
   endtask

   task automatic t_read_empty();
      logic [17:0] w;
      a_pop(w);
      check("R8", "A rd_level after empty read", a_rlvl, 0);
      a_push(9'h111);
      a_push(9'h122);
      settle();
      check("R8", "A rd_level after refill", a_rlvl, 1);
      a_pop(w);
      check("R8", "A data after empty read", w, {9'h122, 9'h111});
   endtask

   task automatic t_fill();
      logic [17:0] w;
      int bad = 0;
      for (int i = 0; i < 512; i++) begin
         a_push(fill_val(i));
         if (i == 498) check("R9", "A almost_full at 499", a_af, 0);
         if (i == 499) check("R9", "A almost_full at 500", a_af, 1);
         if (i == 510) check("R7", "A full at 511", a_full, 0);
      end
      check("R7", "A full at 512", a_full, 1);
      check("R5", "A wr_level at 512", a_wlvl, 512);
      a_push(9'h1FF);
      check("R7", "A wr_level after write while full", a_wlvl, 512);
      settle();
      check("R6", "A rd_level full", a_rlvl, 256);
      for (int j = 0; j < 256; j++) begin
         a_pop(w);
         if (w !== {fill_val(2*j+1), fill_val(2*j)}) begin
            bad++;
            if (bad == 1) check("R7", "A drained word", w, {fill_val(2*j+1), fill_val(2*j)});
         end
      end
      check("R7", "A drain mismatches", bad, 0);
      settle();
      check("R5", "A wr_level after drain", a_wlvl, 0);
      check("R9", "A almost_full after drain", a_af, 0);
      check("R4", "A rd_empty after drain", a_empty, 1);
   endtask

   initial begin
      repeat (3) @(negedge wr_clk);
      t_reset();
      rst_n = 1;
      repeat (3) @(negedge rd_clk);
      t_reset();
      t_pack();
      t_odd_unit();
      t_unpack();
      t_almost_empty();
      t_wr_flush_unaligned();
      t_rd_flush_unaligned();
      t_read_empty();
      t_fill();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin
      #400000;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule